// File: doc/BRIEF.md
# Four-Channel Carry-Compare PWM Driver

This block drives four pulse-width-modulated outputs from one shared period counter. An internal divider turns the system clock into a base tick. On every base tick the period counter moves one step through the values 1 to 255 and never rests on zero. Each channel output is the carry out of adding the counter to that channel's duty value. A duty of 0 therefore never drives the output active, and a duty of 255 always does.

The duty values come from an upstream holding register set. When upstream raises its new-data flag, the block copies all four holding values in the same tick and answers with a one-cycle acknowledge, so the duty set never mixes two frames. A global shutdown forces every output inactive. A per-bit polarity mask inverts the outputs for active-low loads. The base tick is also driven out as a pulse for downstream timers. With the default divider of 77 and a 4 MHz clock, one tick lasts about 19.25 µs and one PWM frame about 4.9 ms.

Top module: `quad_pwm_driver`

## Requirements
- R1: `tick` is a one-cycle pulse asserted once in every TICK_DIV clock cycles. Its first assertion is in the TICK_DIV-th cycle after reset is released.
- R2: The period counter advances by one on every tick. After 255 it goes to 1 instead of 0, so the first tick after reset gives the value 1 and the counter repeats 1..255.
- R3: Channel c (c = 0..3) is active when counter + duty of channel c exceeds 255 (the carry of the 8-bit add). Channel c drives `pwm_out[c]`, and its duty is taken from `hold_duty[8c+7:8c]`. A duty of 0 is never active and a duty of 255 is always active.
- R4: `pwm_out` is registered. All bits change together, only on the clock edge at which `tick` is high, and they hold their value between ticks.
- R5: When `shutdown` is high at a tick, all four channels are inactive in the output produced by that tick, whatever their duty.
- R6: Each `pwm_out[c]` is the channel's active level XORed with `polarity[c]`. A polarity of 1 makes that output active-low. Polarity is applied at the tick update.
- R7: When `new_data` is high at a tick, all four holding values are copied into the duty registers. The output of that same tick still uses the old duties, and the new duties apply from the next tick. While `new_data` is low, changes on `hold_duty` have no effect on the outputs.
- R8: `data_ack` is high for exactly the one cycle after a tick at which `new_data` was high, and low at all other times.
- R9: While reset is low, `pwm_out`, `data_ack` and `tick` are 0, and the counter and the duties are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_duty | input | 32 | Holding duty values, channel c in bits 8c+7:8c |
| new_data | input | 1 | Holding values are ready to be copied |
| shutdown | input | 1 | Force all channels inactive |
| polarity | input | 4 | Per-output inversion mask |
| pwm_out | output | 4 | Registered PWM outputs |
| data_ack | output | 1 | One-cycle pulse: holding values were copied |
| tick | output | 1 | Base tick pulse |

## Verification
The bench keeps 4 channels and 8-bit duties but builds the block with TICK_DIV set to 4. This shortens a full 255-tick frame to about a thousand clocks. At that length the bench can run 64 complete frames in which the four channels together take every one of the 256 duty values, and it compares every output bit on every cycle against arithmetic counter-plus-duty sums. Further frames cover mixed polarity, shutdown under inversion, and holding values that change while `new_data` stays low. The tick spacing is checked on every cycle at the reduced divider.

// File: rtl/pwm_pkg.sv
// Package pwm_pkg
// Shared default sizing for the carry-compare PWM driver.
// Assumes: nothing beyond IEEE 1800-2017 constant elaboration.
package pwm_pkg;
    localparam int DEF_CHANNELS = 4;
    localparam int DEF_DUTY_W   = 8;
    localparam int DEF_TICK_DIV = 77;
endpackage

// File: rtl/pwm_tick_gen.sv
// Module pwm_tick_gen
// Divides the system clock into a one-cycle base tick, once every TICK_DIV
// cycles. The tick is registered.
// Assumes: TICK_DIV >= 2.
module pwm_tick_gen #(
    parameter int TICK_DIV = pwm_pkg::DEF_TICK_DIV
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int          DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    // Count clock cycles and pulse the tick when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + DIV_W'(1);
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_period_counter.sv
// Module pwm_period_counter
// Shared PWM period counter. It steps once per tick and cycles through
// 1..2^DUTY_W-1, never taking the value zero after the first tick.
// Assumes: tick is a single-cycle enable.
module pwm_period_counter #(
    parameter int DUTY_W = pwm_pkg::DEF_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [DUTY_W-1:0] cnt_q,
    output logic [DUTY_W-1:0] cnt_next
);
    localparam logic [DUTY_W-1:0] TOP = {DUTY_W{1'b1}};

    // Next value: increment, with zero replaced by one.
    always_comb begin
        if (cnt_q == TOP) cnt_next = DUTY_W'(1);
        else              cnt_next = cnt_q + DUTY_W'(1);
    end

    // Hold the counter and advance it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_next;
    end
endmodule

// File: rtl/pwm_duty_bank.sv
// Module pwm_duty_bank
// Active duty registers. When the new-data flag is seen at a tick, all
// channels are copied from the holding inputs in one edge and a one-cycle
// acknowledge follows.
// Assumes: the holding values are stable while new_data is high.
module pwm_duty_bank #(
    parameter int CHANNELS = pwm_pkg::DEF_CHANNELS,
    parameter int DUTY_W   = pwm_pkg::DEF_DUTY_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       new_data,
    input  logic [CHANNELS*DUTY_W-1:0] hold_duty,
    output logic [CHANNELS*DUTY_W-1:0] duty_q,
    output logic                       ack_q
);
    logic load;
    assign load = tick & new_data;

    // One register slice per channel, all loaded by the same enable.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_slice
        always_ff @(posedge clk) begin
            if (!rst_n)    duty_q[c*DUTY_W +: DUTY_W] <= '0;
            else if (load) duty_q[c*DUTY_W +: DUTY_W] <= hold_duty[c*DUTY_W +: DUTY_W];
        end
    end

    // Acknowledge pulse in the cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= load;
    end
endmodule

// File: rtl/pwm_output_stage.sv
// Module pwm_output_stage
// Per-channel carry compare of counter plus duty. Applies shutdown and the
// polarity mask, then registers all outputs together on a tick.
// Assumes: cnt is the counter value that takes effect at this tick.
module pwm_output_stage #(
    parameter int CHANNELS = pwm_pkg::DEF_CHANNELS,
    parameter int DUTY_W   = pwm_pkg::DEF_DUTY_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [DUTY_W-1:0]          cnt,
    input  logic [CHANNELS*DUTY_W-1:0] duty,
    input  logic                       shutdown,
    input  logic [CHANNELS-1:0]        polarity,
    output logic [CHANNELS-1:0]        out_q
);
    logic [CHANNELS-1:0] active;

    // Carry of the (DUTY_W+1)-bit sum marks the channel active.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_cmp
        logic [DUTY_W:0] sum;
        assign sum       = {1'b0, cnt} + {1'b0, duty[c*DUTY_W +: DUTY_W]};
        assign active[c] = sum[DUTY_W];
    end

    // Register the gated, polarity-adjusted word on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= '0;
        else if (tick) out_q <= (shutdown ? '0 : active) ^ polarity;
    end
endmodule

// File: rtl/quad_pwm_driver.sv
// Module quad_pwm_driver
// Four-channel carry-compare PWM driver: tick divider, shared period
// counter, duty registers with atomic reload, and a registered output stage.
// Assumes: synchronous active-low reset; TICK_DIV >= 2.
module quad_pwm_driver #(
    parameter int CHANNELS = pwm_pkg::DEF_CHANNELS,
    parameter int DUTY_W   = pwm_pkg::DEF_DUTY_W,
    parameter int TICK_DIV = pwm_pkg::DEF_TICK_DIV
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CHANNELS*DUTY_W-1:0] hold_duty,
    input  logic                       new_data,
    input  logic                       shutdown,
    input  logic [CHANNELS-1:0]        polarity,
    output logic [CHANNELS-1:0]        pwm_out,
    output logic                       data_ack,
    output logic                       tick
);
    logic [DUTY_W-1:0]          cnt_q;
    logic [DUTY_W-1:0]          cnt_next;
    logic [CHANNELS*DUTY_W-1:0] duty_q;

    pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pwm_period_counter #(.DUTY_W(DUTY_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_q(cnt_q), .cnt_next(cnt_next)
    );

    pwm_duty_bank #(.CHANNELS(CHANNELS), .DUTY_W(DUTY_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .tick(tick), .new_data(new_data),
        .hold_duty(hold_duty), .duty_q(duty_q), .ack_q(data_ack)
    );

    pwm_output_stage #(.CHANNELS(CHANNELS), .DUTY_W(DUTY_W)) u_out (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_next),
        .duty(duty_q), .shutdown(shutdown), .polarity(polarity),
        .out_q(pwm_out)
    );
endmodule

// File: rtl/quad_pwm_driver_sva.sv
// Module quad_pwm_driver_sva
// Property checker for quad_pwm_driver, attached by bind.
// Assumes: TICK_DIV >= 2.
module quad_pwm_driver_sva #(
    parameter int CHANNELS = 4,
    parameter int DUTY_W   = 8,
    parameter int TICK_DIV = 77
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       new_data,
    input logic                       shutdown,
    input logic [CHANNELS-1:0]        polarity,
    input logic [CHANNELS-1:0]        pwm_out,
    input logic                       data_ack,
    input logic [DUTY_W-1:0]          cnt_q,
    input logic [CHANNELS*DUTY_W-1:0] duty_q
);
    localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q != '0);

    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm_out));

    a_r5_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shutdown) |=> pwm_out == $past(polarity));

    a_r8_ack_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && new_data) |=> data_ack);

    a_r8_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && new_data) |=> !data_ack);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        a_r3_full_on: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !shutdown && duty_q[c*DUTY_W +: DUTY_W] == FULL)
            |=> pwm_out[c] == !$past(polarity[c]));
        a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && duty_q[c*DUTY_W +: DUTY_W] == '0)
            |=> pwm_out[c] == $past(polarity[c]));
    end
endmodule

bind quad_pwm_driver quad_pwm_driver_sva #(
    .CHANNELS(CHANNELS), .DUTY_W(DUTY_W), .TICK_DIV(TICK_DIV)
) u_sva (
    .clk(clk), .rst_n(rst_n), .tick(tick), .new_data(new_data),
    .shutdown(shutdown), .polarity(polarity), .pwm_out(pwm_out),
    .data_ack(data_ack), .cnt_q(cnt_q), .duty_q(duty_q)
);

// File: tb/sim_quad_pwm_driver.sv
`timescale 1ns/1ps
// Bench sim_quad_pwm_driver
// Cycle-accurate arithmetic model of the driver with a short tick divider.
module sim_quad_pwm_driver;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hold_duty = '0;
    logic        new_data = 1'b0;
    logic        shutdown = 1'b0;
    logic [3:0]  polarity = '0;
    logic [3:0]  pwm_out;
    logic        data_ack;
    logic        tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int         m_div = 0;
    bit         m_tick = 0;
    int         m_cnt = 0;
    int         m_duty [4] = '{0, 0, 0, 0};
    logic [3:0] e_out = '0;
    bit         e_ack = 0;

    quad_pwm_driver #(.CHANNELS(4), .DUTY_W(8), .TICK_DIV(D)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_duty(hold_duty), .new_data(new_data),
        .shutdown(shutdown), .polarity(polarity), .pwm_out(pwm_out),
        .data_ack(data_ack), .tick(tick)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: predict at the falling edge, compare after the rising edge.
    task automatic step();
        logic [3:0] raw;
        @(negedge clk);
        chk("R1 tick", int'(tick), int'(m_tick));
        e_ack = 0;
        if (m_tick) begin
            m_cnt = (m_cnt == 255) ? 1 : m_cnt + 1;
            for (int c = 0; c < 4; c++) raw[c] = (m_cnt + m_duty[c]) > 255;
            e_out = (shutdown ? 4'b0 : raw) ^ polarity;
            if (new_data) begin
                e_ack = 1;
                for (int c = 0; c < 4; c++) m_duty[c] = int'(hold_duty[c*8 +: 8]);
            end
        end
        if (m_div == D - 1) begin m_div = 0; m_tick = 1; end
        else begin m_div++; m_tick = 0; end
        @(posedge clk); #1;
        chk("R2 R3 R4 R5 R6 R7 pwm_out", int'(pwm_out), int'(e_out));
        chk("R8 data_ack", int'(data_ack), int'(e_ack));
        if (data_ack) new_data = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input int d0, input int d1, input int d2, input int d3);
        hold_duty = {8'(d3), 8'(d2), 8'(d1), 8'(d0)};
        new_data  = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset pwm_out", int'(pwm_out), 0);
        chk("R9 reset data_ack", int'(data_ack), 0);
        chk("R9 reset tick", int'(tick), 0);
        rst_n = 1'b1;
        // R3: every duty value over full frames, four values per frame
        for (int k = 0; k < 64; k++) begin
            load(4*k, 4*k + 1, 4*k + 2, 4*k + 3);
            run(256*D + D);
        end
        // R6: mixed polarity with extreme and middle duties
        polarity = 4'b1010;
        load(0, 255, 128, 1);
        run(256*D + D);
        // R5: shutdown under inversion
        shutdown = 1'b1;
        polarity = 4'b0101;
        run(256*D);
        shutdown = 1'b0;
        // R7: holding values change with new_data low, no effect expected
        hold_duty = 32'h11_22_EE_FF;
        run(256*D);
        // R7: reload then confirm one frame
        polarity = 4'b0000;
        load(200, 50, 255, 0);
        run(256*D + D);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule